// File: doc/BRIEF.md
# Paged DMA Address and Count Generator

This block holds the address and transfer-count state for one DMA channel. It produces the physical byte address of the current transfer and reports when the block of transfers is finished. Software, through a host interface outside this block, writes a 16-bit start address, a 16-bit count and an 8-bit page. After that, a step strobe advances the channel once per transfer. The channel runs as a byte channel or as a word channel. In word mode every address is even, and the page supplies only its upper seven bits.

The 16-bit address counter never carries into the page, so a block of transfers stays inside one 64 KiB region (byte mode) or one 128 KiB region (word mode). The count is held as transfers minus one. A step taken while the count is zero is the terminal transfer. When autoinitialize is enabled, the terminal step restores the start values so the next block can run. A residue output gives the number of bytes still to move.

Top module: `paged_dma_gen`

## Requirements
- R1: After synchronous reset, address, count and page are zero, `tc` is 0, `phys_addr` is 0, and `residue` is 1 in byte mode (`word_mode`=0) or 2 in word mode (`word_mode`=1).
- R2: In byte mode, `phys_addr[23:16]` equals the page and `phys_addr[15:0]` equals the current address.
- R3: In word mode, `phys_addr[0]` is 0, `phys_addr[16:1]` equals the current address and `phys_addr[23:17]` equals page bits 7:1. Page bit 0 has no effect.
- R4: A pulse on `ld_addr` or `ld_count` writes `load_data` into both the start register and the current register. A pulse on `ld_page` writes `load_data[7:0]` into the page. The new value is visible after that clock edge.
- R5: An accepted step increments the current address by one and decrements the current count by one.
- R6: The address wraps from 0xFFFF to 0x0000 and leaves the page, and so `phys_addr[23:17]`, unchanged.
- R7: A step taken while the count is 0x0000 sets `tc`, and the count wraps to 0xFFFF.
- R8: When autoinitialize is off, steps while `tc` is 1 are ignored and `tc` stays 1. `tc` clears on any load strobe.
- R9: When `autoinit` is 1, the terminal step also copies the start address and start count into the current registers. The next accepted step clears `tc`.
- R10: `residue` equals (count+1) mod 65536 in byte mode, or twice that value (17 bits) in word mode. It therefore reads 0 after a finished block.
- R11: A step in a cycle that carries any load strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 0 selects a byte channel, 1 selects a word channel |
| autoinit | input | 1 | Restore the start values on the terminal step |
| ld_addr | input | 1 | Load the start and current address |
| ld_count | input | 1 | Load the start and current count |
| ld_page | input | 1 | Load the page register from the low byte |
| load_data | input | 16 | Value written by the load strobes |
| step | input | 1 | Advance one transfer |
| phys_addr | output | 24 | Physical byte address of the current transfer |
| tc | output | 1 | Terminal count reached |
| residue | output | 17 | Bytes remaining in the block |

## Verification
The assertions assume that `word_mode` and `autoinit` change only while the channel is idle between blocks. They also assume that `load_data` is meaningful only in a cycle with a load strobe. The directed tasks change the mode and autoinit inputs only in cycles with no step. Each scenario begins with fresh loads, so every property sees a well-defined start. Steps are issued one per cycle, alone or deliberately paired with a load strobe to exercise the suppression rule.

// File: rtl/dmagen_pkg.sv
package dmagen_pkg;

    localparam int CNT_W  = 16;
    localparam int PAGE_W = 8;
    localparam int PHYS_W = CNT_W + PAGE_W;
    localparam int RES_W  = CNT_W + 1;

    typedef enum logic {
        CH_BYTE = 1'b0,
        CH_WORD = 1'b1
    } chan_width_e;

    typedef struct packed {
        logic load_any;
        logic advance;
        logic terminal;
        logic reload;
    } step_ctl_t;

    function automatic logic [PHYS_W-1:0] map_phys(
        input chan_width_e        w,
        input logic [PAGE_W-1:0]  pg,
        input logic [CNT_W-1:0]   a
    );
        if (w == CH_WORD)
            return {pg[PAGE_W-1:1], a, 1'b0};
        else
            return {pg, a};
    endfunction

    function automatic logic [RES_W-1:0] residue_bytes(
        input chan_width_e       w,
        input logic [CNT_W-1:0]  cnt
    );
        logic [CNT_W-1:0] n;
        n = cnt + 1'b1;
        if (w == CH_WORD)
            return {n, 1'b0};
        else
            return {1'b0, n};
    endfunction

endpackage

// File: rtl/dmagen_ctr.sv
module dmagen_ctr #(
    parameter int W      = 16,
    parameter bit DIR_UP = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         adv,
    input  logic         reload,
    output logic [W-1:0] cur
);

    logic [W-1:0] base_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] nxt;

    generate
        if (DIR_UP) begin : g_up
            assign nxt = cur_q + 1'b1;
            assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
                (adv && !ld && !reload) |=> (cur == W'($past(cur) + 1'b1)));
        end else begin : g_down
            assign nxt = cur_q - 1'b1;
            assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
                (adv && !ld && !reload) |=> (cur == W'($past(cur) - 1'b1)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (ld) begin
            base_q <= ld_val;
            cur_q  <= ld_val;
        end else if (reload) begin
            cur_q  <= base_q;
        end else if (adv) begin
            cur_q  <= nxt;
        end
    end

    assign cur = cur_q;

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cur == $past(ld_val)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv && !reload) |=> $stable(cur));

endmodule

// File: rtl/dmagen_map.sv
module dmagen_map
    import dmagen_pkg::*;
(
    input  chan_width_e        width,
    input  logic [PAGE_W-1:0]  page,
    input  logic [CNT_W-1:0]   addr,
    output logic [PHYS_W-1:0]  phys
);

    assign phys = map_phys(width, page, addr);

    always_comb begin
        if (width == CH_WORD)
            assert_word_even_R3: assert (phys[0] == 1'b0);
    end

endmodule

// File: rtl/paged_dma_gen.sv
module paged_dma_gen
    import dmagen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_mode,
    input  logic              autoinit,
    input  logic              ld_addr,
    input  logic              ld_count,
    input  logic              ld_page,
    input  logic [CNT_W-1:0]  load_data,
    input  logic              step,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              tc,
    output logic [RES_W-1:0]  residue
);

    chan_width_e        width;
    step_ctl_t          ctl;
    logic [PAGE_W-1:0]  page_q;
    logic               tc_q;
    logic [CNT_W-1:0]   addr_cur;
    logic [CNT_W-1:0]   cnt_cur;

    assign width = chan_width_e'(word_mode);

    always_comb begin
        ctl.load_any = ld_addr | ld_count | ld_page;
        ctl.advance  = step & ~ctl.load_any & ~(tc_q & ~autoinit);
        ctl.terminal = ctl.advance & (cnt_cur == '0);
        ctl.reload   = ctl.terminal & autoinit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            tc_q   <= 1'b0;
        end else begin
            if (ld_page)
                page_q <= load_data[PAGE_W-1:0];
            if (ctl.load_any)
                tc_q <= 1'b0;
            else if (ctl.terminal)
                tc_q <= 1'b1;
            else if (ctl.advance)
                tc_q <= 1'b0;
        end
    end

    dmagen_ctr #(.W(CNT_W), .DIR_UP(1'b1)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld_addr),
        .ld_val (load_data),
        .adv    (ctl.advance),
        .reload (ctl.reload),
        .cur    (addr_cur)
    );

    dmagen_ctr #(.W(CNT_W), .DIR_UP(1'b0)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld_count),
        .ld_val (load_data),
        .adv    (ctl.advance),
        .reload (ctl.reload),
        .cur    (cnt_cur)
    );

    dmagen_map u_map (
        .width (width),
        .page  (page_q),
        .addr  (addr_cur),
        .phys  (phys_addr)
    );

    assign tc      = tc_q;
    assign residue = residue_bytes(width, cnt_cur);

    assert_tc_from_step_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tc) |-> $past(step));

    assert_tc_clear_on_load_R8: assert property (@(posedge clk) disable iff (rst)
        (ld_addr || ld_count || ld_page) |=> !tc);

    assert_page_kept_R6: assert property (@(posedge clk) disable iff (rst)
        !ld_page |=> $stable(phys_addr[PHYS_W-1:CNT_W+1]));

    assert_frozen_after_tc_R8: assert property (@(posedge clk) disable iff (rst)
        (tc && !autoinit && !ld_addr && !ld_count && !ld_page)
            |=> ($stable(addr_cur) && $stable(cnt_cur) && tc));

    assert_step_with_load_R11: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_addr && ld_page) |=> $stable(addr_cur));

endmodule

// File: tb/sim_paged_dma_gen.sv
module sim_paged_dma_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_mode = 1'b0;
    logic        autoinit = 1'b0;
    logic        ld_addr = 1'b0;
    logic        ld_count = 1'b0;
    logic        ld_page = 1'b0;
    logic [15:0] load_data = '0;
    logic        step = 1'b0;
    logic [23:0] phys_addr;
    logic        tc;
    logic [16:0] residue;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    paged_dma_gen u0 (
        .clk(clk), .rst(rst), .word_mode(word_mode), .autoinit(autoinit),
        .ld_addr(ld_addr), .ld_count(ld_count), .ld_page(ld_page),
        .load_data(load_data), .step(step),
        .phys_addr(phys_addr), .tc(tc), .residue(residue)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock: drive strobes, cross a rising edge, clear them at the falling edge
    task automatic cyc(input logic la, input logic lc, input logic lp,
                       input logic [15:0] d, input logic st);
        ld_addr = la; ld_count = lc; ld_page = lp; load_data = d; step = st;
        @(negedge clk);
        ld_addr = 0; ld_count = 0; ld_page = 0; load_data = '0; step = 0;
    endtask

    task automatic setup(input logic [7:0] pg, input logic [15:0] a, input logic [15:0] c);
        cyc(0, 0, 1, {8'h00, pg}, 0);
        cyc(1, 0, 0, a, 0);
        cyc(0, 1, 0, c, 0);
    endtask

    task automatic t_reset;
        chk("R1 phys", phys_addr, 32'h0);
        chk("R1 tc", tc, 0);
        chk("R1 residue byte", residue, 1);
        word_mode = 1;
        #1;
        chk("R1 residue word", residue, 2);
        word_mode = 0;
    endtask

    task automatic t_byte_map;
        setup(8'h5A, 16'h1234, 16'h0003);
        chk("R2 byte phys", phys_addr, 32'h5A1234);
        chk("R4 loaded count residue", residue, 4);
        chk("R4 tc cleared", tc, 0);
    endtask

    task automatic t_word_map;
        word_mode = 1;
        setup(8'h5B, 16'h1234, 16'h0003);
        chk("R3 word phys", phys_addr, 32'h5A2468);
        chk("R10 word residue", residue, 8);
        cyc(0, 0, 1, 16'h005A, 0);
        chk("R3 page bit0 ignored", phys_addr, 32'h5A2468);
        word_mode = 0;
    endtask

    task automatic t_step;
        setup(8'h5A, 16'h1234, 16'h0003);
        cyc(0, 0, 0, 16'h0, 1);
        chk("R5 addr inc", phys_addr, 32'h5A1235);
        chk("R5 count dec", residue, 3);
    endtask

    task automatic t_wrap;
        setup(8'h12, 16'hFFFF, 16'h0005);
        cyc(0, 0, 0, 16'h0, 1);
        chk("R6 wrap keeps page", phys_addr, 32'h120000);
    endtask

    task automatic t_terminal;
        setup(8'h00, 16'h0010, 16'h0001);
        cyc(0, 0, 0, 16'h0, 1);
        chk("R5 residue 1", residue, 1);
        chk("R7 no tc yet", tc, 0);
        cyc(0, 0, 0, 16'h0, 1);
        chk("R7 tc set", tc, 1);
        chk("R10 finished residue", residue, 0);
        chk("R7 phys after terminal", phys_addr, 32'h000012);
        cyc(0, 0, 0, 16'h0, 1);
        chk("R8 step ignored phys", phys_addr, 32'h000012);
        chk("R8 tc held", tc, 1);
        cyc(0, 1, 0, 16'h0002, 0);
        chk("R8 load clears tc", tc, 0);
        chk("R8 new count", residue, 3);
    endtask

    task automatic t_autoinit;
        autoinit = 1;
        setup(8'h00, 16'h0100, 16'h0001);
        cyc(0, 0, 0, 16'h0, 1);
        cyc(0, 0, 0, 16'h0, 1);
        chk("R9 tc", tc, 1);
        chk("R9 addr reloaded", phys_addr, 32'h000100);
        chk("R9 count reloaded", residue, 2);
        cyc(0, 0, 0, 16'h0, 1);
        chk("R9 tc cleared by step", tc, 0);
        chk("R9 continues", phys_addr, 32'h000101);
        chk("R9 residue", residue, 1);
        autoinit = 0;
    endtask

    task automatic t_step_with_load;
        setup(8'h00, 16'h0200, 16'h0004);
        cyc(0, 0, 1, 16'h0033, 1);
        chk("R11 addr kept", phys_addr, 32'h330200);
        chk("R11 count kept", residue, 5);
    endtask

    task automatic t_word_finish;
        word_mode = 1;
        setup(8'h02, 16'h0000, 16'h0000);
        chk("R10 word single", residue, 2);
        cyc(0, 0, 0, 16'h0, 1);
        chk("R7 word tc", tc, 1);
        chk("R10 word finished", residue, 0);
        word_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_byte_map();
        t_word_map();
        t_step();
        t_wrap();
        t_terminal();
        t_autoinit();
        t_step_with_load();
        t_word_finish();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule